// File: doc/BRIEF.md
# Parallel EEPROM Write Controller

This block sits between a host and a byte-wide parallel EEPROM of 32768 eight-bit locations whose write cycle is timed inside the memory. The host issues read, single-byte write and page-write requests on a valid/ready command port. The controller turns each request into strobe sequences on the memory pins. These are chip enable, output enable and write enable, all active low, together with the 15-bit address and a split data bus (`mem_dq_out`, `mem_dq_oe`, `mem_dq_in`) that the pad ring joins into one bidirectional bus.

After the last byte of a write, the controller reads the same address repeatedly and watches data bit 6. While the memory is still programming, that bit changes on every read. Once two reads in a row return the same value, the write has finished and the controller reports completion. It therefore needs no record of the data it wrote. A polling timeout ends the wait with an error flag. After reset, reads stay blocked for a power-up delay and writes for a longer one. Both delays are counted in clock cycles derived from a clock-frequency parameter.

The controller has four states. `ST_IDLE` waits for a command. `ST_SETUP` presents the address for `T_SETUP` cycles. `ST_STROBE` holds the strobes low for `T_PULSE` cycles. `ST_RECOVER` keeps the address for `T_HOLD` cycles with the strobes released. The operation register (`OP_READ`, `OP_WRITE`, `OP_POLL`) selects the path taken at each transition:

| From | To | Condition |
|---|---|---|
| `ST_IDLE` | `ST_SETUP` | A command is accepted and passes its checks. |
| `ST_SETUP` | `ST_STROBE` | The setup time has elapsed. |
| `ST_STROBE` | `ST_RECOVER` | The pulse time has elapsed. |
| `ST_RECOVER` | `ST_SETUP` | More bytes remain in the page, or polling has to go on. When the last byte has been written, the operation switches to `OP_POLL` here. |
| `ST_RECOVER` | `ST_IDLE` | A read ends, the poll matches, or the poll time runs out. |
| `ST_IDLE` | `ST_IDLE` | A write with an illegal span is rejected. |

Top module: `eew_ctrl`

## Requirements
- R1: In a read strobe, `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1. In a write strobe, `mem_ce_n`=0, `mem_we_n`=0 and `mem_oe_n`=1. Outside strobes, all three are 1. Out of reset, all three are 1 and `busy`, `done` and `mem_dq_oe` are 0.
- R2: Each strobe stays low for exactly `T_PULSE` cycles. The address is stable for at least `T_SETUP` cycles before the strobe falls, and it holds until `T_HOLD` cycles after the strobe rises.
- R3: `mem_dq_oe` is 1 only while `mem_we_n` is 0. It is never 1 while `mem_oe_n` is 0.
- R4: A write of `cmd_len` bytes (1 to 64) at `cmd_addr` gives `cmd_len` write strobes at consecutive addresses. Each strobe takes the next byte from `wr_data` with one `dat_pop`, and address bits 14..6 stay constant through the burst.
- R5: A write whose `cmd_len` is 0, or whose `cmd_addr[5:0]+cmd_len` exceeds 64, produces no strobe. `done` is then raised with `err_range`=1 in the cycle after acceptance.
- R6: After the last byte, the controller reads the last address until two consecutive reads agree in bit 6. Only then does it raise `done` with both error flags 0. `done` never comes while the memory is still programming.
- R7: If bit 6 keeps changing for `POLL_US` microseconds, polling stops and `done` is raised with `err_timeout`=1.
- R8: A read returns the byte stored at `cmd_addr` on `rd_data` in the cycle `done` is high.
- R9: After reset, `cmd_ready` stays 0 for read commands during the first `RD_WAIT_US` microseconds and for write commands during the first `WR_WAIT_US` microseconds. It then becomes 1.
- R10: `busy` is 1 from the cycle after acceptance until `done`. `cmd_ready` is 0 while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted when high with `cmd_valid` |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 15 | Start address |
| cmd_len | input | 7 | Byte count of a write (1..64) |
| wr_data | input | 8 | Next write byte, taken when `dat_pop` is high |
| dat_pop | output | 1 | Consumes the current `wr_data` byte |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Read result, valid with `done` |
| err_range | output | 1 | Write span rejected, valid with `done` |
| err_timeout | output | 1 | Completion polling timed out, valid with `done` |
| busy | output | 1 | A command is in progress |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_out | output | 8 | Data to the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
The bench sweeps page writes of 1 to 64 bytes at page starts, at page ends and at odd offsets, and then reads back every location of a modelled memory. A controller that stepped the address or the byte order wrongly, or that let a burst leave its page, would leave wrong bytes behind. It also aims at the moment of completion, checking that the model has stopped programming when `done` appears. A controller that compared too few reads, or the wrong bit, would finish early. Spans one byte past a page, a zero length, and a memory whose bit 6 never settles test the rejection and timeout paths. The power-up windows are probed just before and just after each delay expires, which catches an off-by-scale delay or the read and write limits being swapped.

// File: rtl/eew_pkg.sv
package eew_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_RECOVER} eew_state_e;
    typedef enum logic [1:0] {OP_READ, OP_WRITE, OP_POLL} eew_op_e;
endpackage

// File: rtl/eew_cycle_timer.sv
module eew_cycle_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/eew_pwrup.sv
module eew_pwrup #(
    parameter int RD_CYC = 100,
    parameter int WR_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    output logic rd_ok,
    output logic wr_ok
);
    localparam int W = $clog2(WR_CYC + 1);
    localparam logic [W-1:0] RD_LIM = W'(RD_CYC);
    localparam logic [W-1:0] WR_LIM = W'(WR_CYC);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q < WR_LIM) cnt_q <= cnt_q + W'(1);
    end

    assign rd_ok = (cnt_q >= RD_LIM);
    assign wr_ok = (cnt_q >= WR_LIM);

    // R9: once writes are allowed they stay allowed
    assert_wr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> wr_ok);
    // R9: the write window never opens before the read window
    assert_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |-> rd_ok);
endmodule

// File: rtl/eew_ctrl.sv
module eew_ctrl #(
    parameter int CLK_HZ     = 125_000_000,
    parameter int RD_WAIT_US = 100,
    parameter int WR_WAIT_US = 5000,
    parameter int POLL_US    = 10000,
    parameter int T_SETUP    = 2,
    parameter int T_PULSE    = 3,
    parameter int T_HOLD     = 2,
    parameter int PAGE_BYTES = 64,
    parameter int AW         = 15,
    parameter int DW         = 8,
    parameter int TOGGLE_BIT = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cmd_valid,
    output logic                              cmd_ready,
    input  logic                              cmd_write,
    input  logic [AW-1:0]                     cmd_addr,
    input  logic [$clog2(PAGE_BYTES+1)-1:0]   cmd_len,
    input  logic [DW-1:0]                     wr_data,
    output logic                              dat_pop,
    output logic                              done,
    output logic [DW-1:0]                     rd_data,
    output logic                              err_range,
    output logic                              err_timeout,
    output logic                              busy,
    output logic                              mem_ce_n,
    output logic                              mem_oe_n,
    output logic                              mem_we_n,
    output logic [AW-1:0]                     mem_addr,
    output logic [DW-1:0]                     mem_dq_out,
    output logic                              mem_dq_oe,
    input  logic [DW-1:0]                     mem_dq_in
);
    import eew_pkg::*;

    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int RD_CYC     = RD_WAIT_US * CYC_PER_US;
    localparam int WR_CYC     = WR_WAIT_US * CYC_PER_US;
    localparam int POLL_CYC   = POLL_US * CYC_PER_US;
    localparam int LW         = $clog2(PAGE_BYTES + 1);
    localparam int PW         = $clog2(PAGE_BYTES);
    localparam int PHW        = $clog2(T_SETUP + T_PULSE + T_HOLD + 1);
    localparam int POW        = $clog2(POLL_CYC + 1);
    localparam logic [PHW-1:0] PH_SETUP = PHW'(T_SETUP - 1);
    localparam logic [PHW-1:0] PH_PULSE = PHW'(T_PULSE - 1);
    localparam logic [PHW-1:0] PH_HOLD  = PHW'(T_HOLD - 1);

    eew_state_e          st_q, st_nx;
    eew_op_e             op_q, op_nx;
    logic [AW-1:0]       addr_q, addr_nx;
    logic [LW-1:0]       left_q, left_nx;
    logic [DW-1:0]       dq_q, dq_nx, rdat_q, rdat_nx;
    logic                first_q, first_nx, mark_q, mark_nx;
    logic                done_nx, erng_nx, eto_nx;
    logic                ph_load, ph_done, poll_load, poll_exp;
    logic [PHW-1:0]      ph_val;
    logic                rd_ok, wr_ok;
    logic [LW:0]         span;
    logic                bad_span;

    eew_pwrup #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) u_pwrup (
        .clk(clk), .rst_n(rst_n), .rd_ok(rd_ok), .wr_ok(wr_ok));

    eew_cycle_timer #(.W(PHW)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .expired(ph_done));

    eew_cycle_timer #(.W(POW)) u_poll (
        .clk(clk), .rst_n(rst_n), .load(poll_load), .load_val(POW'(POLL_CYC)), .expired(poll_exp));

    assign span      = (LW+1)'(cmd_addr[PW-1:0]) + (LW+1)'(cmd_len);
    assign bad_span  = (cmd_len == '0) || (span > (LW+1)'(PAGE_BYTES));
    assign cmd_ready = (st_q == ST_IDLE) && (cmd_write ? wr_ok : rd_ok);
    assign busy      = (st_q != ST_IDLE);

    // next-state and datapath decisions
    always_comb begin
        st_nx = st_q;   op_nx = op_q;     addr_nx = addr_q; left_nx = left_q;
        dq_nx = dq_q;   rdat_nx = rdat_q; first_nx = first_q; mark_nx = mark_q;
        done_nx = 1'b0; erng_nx = 1'b0;   eto_nx = 1'b0;
        ph_load = 1'b0; ph_val = '0;      poll_load = 1'b0; dat_pop = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_valid && cmd_ready) begin
                    if (cmd_write && bad_span) begin
                        done_nx = 1'b1;
                        erng_nx = 1'b1;
                    end else begin
                        st_nx   = ST_SETUP;
                        op_nx   = cmd_write ? OP_WRITE : OP_READ;
                        addr_nx = cmd_addr;
                        left_nx = cmd_len;
                        ph_load = 1'b1;
                        ph_val  = PH_SETUP;
                    end
                end
            end
            ST_SETUP: begin
                if (ph_done) begin
                    st_nx   = ST_STROBE;
                    ph_load = 1'b1;
                    ph_val  = PH_PULSE;
                    if (op_q == OP_WRITE) begin
                        dat_pop = 1'b1;
                        dq_nx   = wr_data;
                    end
                end
            end
            ST_STROBE: begin
                if (ph_done) begin
                    st_nx   = ST_RECOVER;
                    ph_load = 1'b1;
                    ph_val  = PH_HOLD;
                    if (op_q != OP_WRITE) rdat_nx = mem_dq_in;
                end
            end
            ST_RECOVER: begin
                if (ph_done) begin
                    unique case (op_q)
                        OP_READ: begin
                            st_nx   = ST_IDLE;
                            done_nx = 1'b1;
                        end
                        OP_WRITE: begin
                            st_nx   = ST_SETUP;
                            ph_load = 1'b1;
                            ph_val  = PH_SETUP;
                            if (left_q > LW'(1)) begin
                                left_nx = left_q - LW'(1);
                                addr_nx = {addr_q[AW-1:PW], addr_q[PW-1:0] + PW'(1)};
                            end else begin
                                op_nx     = OP_POLL;
                                first_nx  = 1'b1;
                                poll_load = 1'b1;
                            end
                        end
                        OP_POLL: begin
                            if (!first_q && rdat_q[TOGGLE_BIT] == mark_q) begin
                                st_nx   = ST_IDLE;
                                done_nx = 1'b1;
                            end else if (!first_q && poll_exp) begin
                                st_nx   = ST_IDLE;
                                done_nx = 1'b1;
                                eto_nx  = 1'b1;
                            end else begin
                                first_nx = 1'b0;
                                mark_nx  = rdat_q[TOGGLE_BIT];
                                st_nx    = ST_SETUP;
                                ph_load  = 1'b1;
                                ph_val   = PH_SETUP;
                            end
                        end
                        default: st_nx = ST_IDLE;
                    endcase
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;  op_q <= OP_READ;  addr_q <= '0;  left_q <= '0;
            dq_q <= '0;       rdat_q <= '0;     first_q <= 1'b0; mark_q <= 1'b0;
            done <= 1'b0;     err_range <= 1'b0; err_timeout <= 1'b0;
        end else begin
            st_q <= st_nx;    op_q <= op_nx;    addr_q <= addr_nx; left_q <= left_nx;
            dq_q <= dq_nx;    rdat_q <= rdat_nx; first_q <= first_nx; mark_q <= mark_nx;
            done <= done_nx;  err_range <= erng_nx; err_timeout <= eto_nx;
        end
    end

    // pin outputs
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        if (st_q == ST_STROBE) begin
            mem_ce_n = 1'b0;
            if (op_q == OP_WRITE) begin
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end else begin
                mem_oe_n = 1'b0;
            end
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = dq_q;
    assign rd_data    = rdat_q;

    // R2: address does not move during a strobe or its recovery
    assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STROBE || st_q == ST_RECOVER) |-> $stable(mem_addr));
    // R3: bus already released in the cycle before output enable falls
    assert_bus_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (!mem_dq_oe && $past(!mem_dq_oe)));
    // R4: the page part of the address is frozen during a write burst
    assert_page_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_WRITE && st_q != ST_IDLE) |=>
        (op_q != OP_WRITE || st_q == ST_IDLE || $stable(addr_q[AW-1:PW])));
    // R4: every popped byte is followed by a write strobe
    assert_pop_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dat_pop |=> !mem_we_n);
    // R9: no write is accepted before the write delay has elapsed
    assert_write_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_write) |-> wr_ok);
    // R10: completion is only reported once the controller is idle again
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/test_eew_ctrl.sv
`timescale 1ns/1ps
module test_eew_ctrl;
    localparam int TS = 2, TP = 3, TH = 1;
    localparam int POLL = 1500;
    localparam int BUSY_CYC = 200;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [14:0] cmd_addr = '0;
    logic [6:0] cmd_len = '0;
    logic [7:0] wr_data, rd_data, mem_dq_out, mem_dq_in;
    logic cmd_ready, dat_pop, done, err_range, err_timeout, busy;
    logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [14:0] mem_addr;

    int checks = 0, fails = 0, wd = 0;
    int enc_viol = 0, bus_viol = 0, pw_viol = 0, page_viol = 0, setup_viol = 0, busy_bad = 0;
    int we_cnt = 0, we_run = 0, oe_run = 0, addr_age = 0;
    logic [14:0] prev_addr = '0;
    logic prev_ce = 1'b1;
    logic [8:0] exp_page = '0;
    logic [14:0] cur_base = '0;
    int k = 0;

    logic [7:0] mem [256];
    logic [7:0] expm [256];
    int bcnt = 0;
    logic stuck = 1'b0, tog = 1'b0;
    logic dev_busy;

    always #4 clk = ~clk;

    eew_ctrl #(.CLK_HZ(1_000_000), .RD_WAIT_US(100), .WR_WAIT_US(3000), .POLL_US(POLL),
               .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH)) i_eew_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .wr_data(wr_data),
        .dat_pop(dat_pop), .done(done), .rd_data(rd_data), .err_range(err_range),
        .err_timeout(err_timeout), .busy(busy), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

    function automatic logic [7:0] pat(input logic [14:0] a);
        return 8'(a * 37) + 8'h1B;
    endfunction

    // memory model: self-timed write, bit 6 toggles per read while programming
    assign dev_busy  = (bcnt != 0) || stuck;
    assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ?
        (dev_busy ? {mem[mem_addr[7:0]][7], tog, mem[mem_addr[7:0]][5:0]} : mem[mem_addr[7:0]]) : 8'h00;
    assign wr_data = pat(cur_base + 15'(k));

    always @(posedge clk) begin
        if (!mem_we_n && !mem_ce_n) begin
            mem[mem_addr[7:0]] <= mem_dq_out;
            bcnt <= BUSY_CYC;
        end else if (bcnt != 0) bcnt <= bcnt - 1;
        if (cmd_valid && cmd_ready) k <= 0;
        else if (dat_pop) k <= k + 1;
    end
    always @(negedge mem_oe_n) if (dev_busy) tog <= ~tog;
    always @(negedge mem_we_n) we_cnt++;

    // pin monitor
    always @(negedge clk) if (rst_n) begin
        if (!mem_we_n && (mem_ce_n || !mem_oe_n)) enc_viol++;
        if (!mem_oe_n && (mem_ce_n || !mem_we_n)) enc_viol++;
        if (mem_ce_n && (!mem_oe_n || !mem_we_n)) enc_viol++;
        if (mem_dq_oe && (mem_we_n || !mem_oe_n)) bus_viol++;
        if (!mem_we_n && mem_addr[14:6] != exp_page) page_viol++;
        if (!mem_we_n) we_run++; else if (we_run != 0) begin if (we_run != TP) pw_viol++; we_run = 0; end
        if (!mem_oe_n) oe_run++; else if (oe_run != 0) begin if (oe_run != TP) pw_viol++; oe_run = 0; end
        if (prev_ce && !mem_ce_n && addr_age < TS) setup_viol++;
        if (mem_addr != prev_addr) addr_age = 1; else addr_age++;
        prev_addr = mem_addr;
        prev_ce = mem_ce_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_cmd(input bit wr, input logic [14:0] a, input int n, output int cyc);
        @(negedge clk);
        cmd_write = wr; cmd_addr = a; cmd_len = 7'(n); cmd_valid = 1'b1;
        cur_base = a; exp_page = a[14:6]; we_cnt = 0;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 20000) begin
            if (!busy || cmd_ready) busy_bad++;
            @(negedge clk);
            cyc++;
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            checks++; fails++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", wd, 190000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int cyc;
        int bases [8] = '{0, 74, 75, 128, 129, 191, 15'h7FC0, 224};
        int lens  [8] = '{64, 1, 53, 1, 2, 1, 16, 32};
        for (int i = 0; i < 256; i++) begin mem[i] = 8'(i) ^ 8'hC3; expm[i] = 8'(i) ^ 8'hC3; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !busy && !done, "R1 reset pins",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, busy, done}, 6'b111000);
        rst_n = 1'b1;
        // R9 power-up windows
        repeat (90) @(negedge clk);
        cmd_write = 1'b0;
        #1 chk(!cmd_ready, "R9 read blocked early", cmd_ready, 0);
        repeat (20) @(negedge clk);
        #1 chk(cmd_ready, "R9 read allowed", cmd_ready, 1);
        cmd_write = 1'b1;
        #1 chk(!cmd_ready, "R9 write blocked early", cmd_ready, 0);
        repeat (2880) @(negedge clk);
        #1 chk(!cmd_ready, "R9 write blocked before delay", cmd_ready, 0);
        repeat (20) @(negedge clk);
        #1 chk(cmd_ready, "R9 write allowed", cmd_ready, 1);
        // R8 reads of initial contents
        for (int a = 3; a < 260; a += 64) begin
            run_cmd(1'b0, 15'(a), 0, cyc);
            chk(rd_data == expm[a[7:0]], "R8 initial read", rd_data, expm[a[7:0]]);
        end
        // R4 R6 write sweep
        for (int t = 0; t < 8; t++) begin
            run_cmd(1'b1, 15'(bases[t]), lens[t], cyc);
            chk(done && !err_range && !err_timeout, "R6 write done clean", {err_range, err_timeout}, 0);
            chk(we_cnt == lens[t], "R4 strobe count", we_cnt, lens[t]);
            chk(!dev_busy, "R6 memory idle at done", dev_busy, 0);
            chk(cyc >= BUSY_CYC, "R6 waited for programming", cyc, BUSY_CYC);
            for (int i = 0; i < lens[t]; i++) expm[8'(bases[t] + i)] = pat(15'(bases[t] + i));
        end
        // R5 span rejects
        begin
            int rb [3] = '{15'h0C7C, 0, 0};
            int rl [3] = '{5, 0, 65};
            for (int t = 0; t < 3; t++) begin
                run_cmd(1'b1, 15'(rb[t]), rl[t], cyc);
                chk(done && err_range && cyc == 1, "R5 reject timing", cyc, 1);
                chk(we_cnt == 0, "R5 no strobe", we_cnt, 0);
            end
        end
        // R8 full readback
        for (int a = 0; a < 256; a++) begin
            run_cmd(1'b0, 15'(a), 0, cyc);
            chk(rd_data == expm[a], "R8 readback", rd_data, expm[a]);
        end
        // R7 timeout
        stuck = 1'b1;
        run_cmd(1'b1, 15'h0010, 1, cyc);
        chk(done && err_timeout && !err_range, "R7 timeout flag", err_timeout, 1);
        chk(cyc >= POLL && cyc <= POLL + 40, "R7 timeout time", cyc, POLL);
        stuck = 1'b0;
        repeat (BUSY_CYC + 5) @(negedge clk);
        expm[8'h10] = pat(15'h0010);
        run_cmd(1'b0, 15'h0010, 0, cyc);
        chk(rd_data == expm[8'h10], "R8 read after timeout", rd_data, expm[8'h10]);
        // aggregated pin checks
        chk(enc_viol == 0, "R1 strobe encoding", enc_viol, 0);
        chk(pw_viol == 0, "R2 pulse width", pw_viol, 0);
        chk(setup_viol == 0, "R2 address setup", setup_viol, 0);
        chk(bus_viol == 0, "R3 bus drive window", bus_viol, 0);
        chk(page_viol == 0, "R4 page kept", page_viol, 0);
        chk(busy_bad == 0, "R10 busy and ready", busy_bad, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule